// File: doc/BRIEF.md
# Bus-Master Read Channel Request Controller

This block decides when a bus-master read channel should ask for the system bus to fill its inbound FIFO. It looks at three things: a programmed transfer count, a transfer-enable control bit, and a threshold-mode control bit. It compares these against the number of free slots in an inbound FIFO. From that it raises or withdraws a bus request. While the grant is present, one word per clock enters the FIFO and the count steps down. When the count reaches zero, a done flag is raised.

The threshold mode keeps the channel from asking for the bus for only a word or two. With the mode bit set, an idle channel requests only when at least four slots are free. Once the bus is granted, or the write channel already holds it, one free slot is enough. A write-only, self-clearing status-reset bit returns the FIFO flags to the empty state: empty set, full clear and four-plus-free set. The write channel is represented only by a "bus already held" input.

Top module: `rdchan_req_ctrl`

## Requirements
- R1: `bus_req` is 0 whenever the transfer-enable bit (control bit 0) reads 0. Clearing that bit drops the request from the next cycle onward and suspends an active transfer.
- R2: `bus_req` is 0 whenever the transfer count is 0. A transfer is active only while its count is nonzero.
- R3: With threshold mode (control bit 1) set, and with neither `bus_gnt` nor `bus_owned_other` high, `bus_req` is 0 unless at least 4 FIFO slots are free.
- R4: With threshold mode clear, an enabled channel with a nonzero count requests whenever at least 1 FIFO slot is free.
- R5: While `bus_gnt` or `bus_owned_other` is high, one free slot is enough to request in either threshold mode.
- R6: In every cycle where `bus_gnt` and `bus_req` are both high, `bus_data` is written into the FIFO and the count decreases by 1. The request drops while the FIFO is full (8 words).
- R7: When the count steps from 1 to 0, the request drops and `xfer_done` becomes 1. Loading a new count clears `xfer_done`.
- R8: Writing 1 to control bit 2 (status reset) produces a one-cycle internal pulse. The cycle after the pulse, the FIFO is emptied: `fifo_empty`=1, `fifo_full`=0, `fifo_four_plus`=1. The request is withheld during the pulse cycle.
- R9: Control bit 2 always reads 0 on `ctl_rdata`. Bits 0 and 1 read back the values last written.
- R10: The FIFO returns words in arrival order. `fifo_empty` is high at 0 words, `fifo_full` at 8 words, and `fifo_four_plus` while at least 4 slots are free.
- R11: After a suspend, setting the enable bit again resumes the transfer from the remaining count. No words are lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control write value: bit0 enable, bit1 threshold mode, bit2 status reset |
| ctl_rdata | output | 3 | Control read value; bit2 is always 0 |
| cnt_load | input | 1 | Load a new transfer count |
| cnt_value | input | 16 | Transfer count to load |
| xfer_count | output | 16 | Remaining transfer count |
| xfer_done | output | 1 | Count has reached 0 through transfers |
| bus_gnt | input | 1 | Bus granted to this channel |
| bus_owned_other | input | 1 | Bus already held by the write channel |
| bus_req | output | 1 | Bus request |
| bus_data | input | 32 | Word delivered by the bus in a granted cycle |
| pop | input | 1 | Consumer takes the head word |
| pop_data | output | 32 | Head word of the FIFO |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds 8 words |
| fifo_four_plus | output | 1 | At least 4 FIFO slots are free |

## Verification
The bench builds the block with its default parameters: an 8-word FIFO, a 16-bit count and a threshold of 4. With these values the FIFO can be driven to full in a few granted cycles. A level of 5 words leaves only 3 free slots, just below the threshold, so the two threshold modes and the held-bus override can be compared on the same FIFO level. Counts of 3 to 20 are enough to reach completion, full-FIFO stalls and suspend/resume quickly.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;

    localparam int CTL_W       = 3;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_THR_BIT = 1;
    localparam int CTL_CLR_BIT = 2;

    typedef struct packed {
        logic en;
        logic thr4;
        logic clr;
    } ctl_t;

endpackage

// File: rtl/rdreq_ctl.sv
module rdreq_ctl
    import rdreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic             en,
    output logic             thr4,
    output logic             clr_pulse,
    output logic [CTL_W-1:0] rdata
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.clr = 1'b0;
        if (we) begin
            ctl_d.en   = wdata[CTL_EN_BIT];
            ctl_d.thr4 = wdata[CTL_THR_BIT];
            ctl_d.clr  = wdata[CTL_CLR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata              = '0;
        rdata[CTL_EN_BIT]  = ctl_q.en;
        rdata[CTL_THR_BIT] = ctl_q.thr4;
    end

    assign en        = ctl_q.en;
    assign thr4      = ctl_q.thr4;
    assign clr_pulse = ctl_q.clr;

    // R8: the reset pulse lasts one cycle unless it is written again
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !(we && wdata[CTL_CLR_BIT])) |=> !clr_pulse);

    // R9: the status-reset bit never reads back as 1
    a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[CTL_CLR_BIT] == 1'b0);

endmodule

// File: rtl/rdreq_fifo.sv
module rdreq_fifo #(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int THR_HI = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] vacant,
    output logic          empty,
    output logic          full,
    output logic          four_plus
);

    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
    localparam logic [LW-1:0] THR_L   = LW'(THR_HI);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } fst_t;

    fst_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty     = (st_q.lvl == '0);
    assign full      = (st_q.lvl == DEPTH_L);
    assign vacant    = DEPTH_L - st_q.lvl;
    assign four_plus = (vacant >= THR_L);
    assign do_push   = push && !full && !clr;
    assign do_pop    = pop && !empty && !clr;
    assign pop_data  = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + AW'(1);
            if (do_pop)  st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + AW'(1);
            case ({do_push, do_pop})
                2'b10:   st_d.lvl = st_q.lvl + LW'(1);
                2'b01:   st_d.lvl = st_q.lvl - LW'(1);
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    // R10: fill level never exceeds the depth
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= DEPTH_L);

    // R8: a clear pulse leaves the flags in the empty state
    a_r8_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full && four_plus));

    // R10: an accepted lone push raises the level by one
    a_r10_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full && !clr) |=> (vacant == $past(vacant) - LW'(1)));

endmodule

// File: rtl/rdreq_decide.sv
module rdreq_decide #(
    parameter int CNT_W  = 16,
    parameter int LW     = 4,
    parameter int THR_HI = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             thr4,
    input  logic             hold_off,
    input  logic [LW-1:0]    vacant,
    input  logic             bus_gnt,
    input  logic             bus_owned_other,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    output logic             bus_req,
    output logic             beat,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [LW-1:0] NEED_HI = LW'(THR_HI);
    localparam logic [LW-1:0] NEED_LO = LW'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } dst_t;

    dst_t st_d, st_q;
    logic held, room_ok, active;
    logic [LW-1:0] need;

    assign held    = bus_gnt || bus_owned_other;
    assign need    = (thr4 && !held) ? NEED_HI : NEED_LO;
    assign room_ok = (vacant >= need);
    assign active  = (st_q.cnt != '0);
    assign bus_req = en && active && room_ok && !hold_off;
    assign beat    = bus_gnt && bus_req;

    always_comb begin
        st_d = st_q;
        if (cnt_load) begin
            st_d.cnt  = cnt_value;
            st_d.done = 1'b0;
        end else if (beat) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign done  = st_q.done;

    // R1: no request while transfers are disabled
    a_r1_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !bus_req);

    // R3: idle channel in threshold mode waits for four free slots
    a_r3_threshold_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (thr4 && !bus_gnt && !bus_owned_other && vacant < NEED_HI) |-> !bus_req);

    // R6: each transferred word consumes one count
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !cnt_load) |=> (count == $past(count) - CNT_W'(1)));

    // R7: the last word sets done and stops the request
    a_r7_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !cnt_load && count == CNT_W'(1)) |=> (done && !bus_req));

endmodule

// File: rtl/rdchan_req_ctrl.sv
module rdchan_req_ctrl
    import rdreq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int THR_HI = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    output logic [2:0]       ctl_rdata,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] xfer_count,
    output logic             xfer_done,
    input  logic             bus_gnt,
    input  logic             bus_owned_other,
    output logic             bus_req,
    input  logic [DW-1:0]    bus_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_four_plus
);

    localparam int LW = $clog2(DEPTH + 1);

    logic          en, thr4, clr_pulse, beat;
    logic [LW-1:0] vacant;

    rdreq_ctl i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we),
        .wdata     (ctl_wdata),
        .en        (en),
        .thr4      (thr4),
        .clr_pulse (clr_pulse),
        .rdata     (ctl_rdata)
    );

    rdreq_decide #(
        .CNT_W  (CNT_W),
        .LW     (LW),
        .THR_HI (THR_HI)
    ) i_decide (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .thr4            (thr4),
        .hold_off        (clr_pulse),
        .vacant          (vacant),
        .bus_gnt         (bus_gnt),
        .bus_owned_other (bus_owned_other),
        .cnt_load        (cnt_load),
        .cnt_value       (cnt_value),
        .bus_req         (bus_req),
        .beat            (beat),
        .count           (xfer_count),
        .done            (xfer_done)
    );

    rdreq_fifo #(
        .DW     (DW),
        .DEPTH  (DEPTH),
        .THR_HI (THR_HI)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_pulse),
        .push      (beat),
        .push_data (bus_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .vacant    (vacant),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .four_plus (fifo_four_plus)
    );

    // R6: a full FIFO never sees a request
    a_r6_full_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !bus_req);

    // R2: no request without a remaining count
    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count == '0) |-> !bus_req);

endmodule

// File: tb/test_rdchan_req_ctrl.sv
module test_rdchan_req_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [2:0]  ctl_rdata;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_value = '0;
    logic [15:0] xfer_count;
    logic        xfer_done;
    logic        bus_gnt = 1'b0;
    logic        bus_owned_other = 1'b0;
    logic        bus_req;
    logic [31:0] bus_data = '0;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        fifo_empty, fifo_full, fifo_four_plus;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rdchan_req_ctrl i_rdchan_req_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cnt_load(cnt_load), .cnt_value(cnt_value),
        .xfer_count(xfer_count), .xfer_done(xfer_done), .bus_gnt(bus_gnt),
        .bus_owned_other(bus_owned_other), .bus_req(bus_req), .bus_data(bus_data),
        .pop(pop), .pop_data(pop_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_four_plus(fifo_four_plus)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic e, input logic t, input logic c);
        ctl_we = 1'b1;
        ctl_wdata = {c, t, e};
        @(negedge clk);
        ctl_we = 1'b0;
        #1;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_load = 1'b1;
        cnt_value = v;
        @(negedge clk);
        cnt_load = 1'b0;
        #1;
    endtask

    task automatic grant_cycles(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            bus_gnt = 1'b1;
            bus_data = base + 32'(i);
            @(negedge clk);
        end
        bus_gnt = 1'b0;
        #1;
    endtask

    task automatic pop_one();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        #1;
    endtask

    task automatic flush();
        ctl_write(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R10 reset empty", 32'(fifo_empty), 1);
        chk("R10 reset full", 32'(fifo_full), 0);
        chk("R10 reset four_plus", 32'(fifo_four_plus), 1);
        chk("R2 reset req", 32'(bus_req), 0);
        chk("R7 reset done", 32'(xfer_done), 0);
        chk("R9 reset rdata", 32'(ctl_rdata), 0);
    endtask

    task automatic t_gate();
        load_cnt(16'd6);
        chk("R1 disabled no req", 32'(bus_req), 0);
        ctl_write(1'b1, 1'b0, 1'b0);
        chk("R1 enabled req", 32'(bus_req), 1);
        chk("R4 one slot enough", 32'(bus_req), 1);
        load_cnt(16'd0);
        chk("R2 zero count no req", 32'(bus_req), 0);
        ctl_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fill_order();
        load_cnt(16'd20);
        ctl_write(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            bus_gnt = 1'b1;
            bus_data = 32'hC0DE_0000 + 32'(i);
            #1;
            chk("R6 req until full", 32'(bus_req), (i < 8) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        bus_gnt = 1'b0;
        #1;
        chk("R10 full flag", 32'(fifo_full), 1);
        chk("R10 four_plus when full", 32'(fifo_four_plus), 0);
        chk("R6 count after 8 words", 32'(xfer_count), 12);
        for (int i = 0; i < 8; i++) begin
            chk("R10 pop order", pop_data, 32'hC0DE_0000 + 32'(i));
            pop_one();
            if (i == 3) chk("R10 four_plus at 4 free", 32'(fifo_four_plus), 1);
            if (i == 2) chk("R10 four_plus at 3 free", 32'(fifo_four_plus), 0);
        end
        chk("R10 empty after drain", 32'(fifo_empty), 1);
        ctl_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_threshold();
        load_cnt(16'd12);
        ctl_write(1'b1, 1'b0, 1'b0);
        grant_cycles(5, 32'h0000_1000);
        chk("R6 count after 5", 32'(xfer_count), 7);
        chk("R4 3 free mode0 req", 32'(bus_req), 1);
        ctl_write(1'b1, 1'b1, 1'b0);
        chk("R3 3 free mode1 no req", 32'(bus_req), 0);
        bus_owned_other = 1'b1;
        #1;
        chk("R5 held by other req", 32'(bus_req), 1);
        bus_owned_other = 1'b0;
        bus_gnt = 1'b1;
        bus_data = 32'h0000_2000;
        #1;
        chk("R5 granted req", 32'(bus_req), 1);
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk("R5 granted word taken", 32'(xfer_count), 6);
        for (int i = 0; i < 3; i++) pop_one();
        chk("R3 5 free mode1 req", 32'(bus_req), 1);
    endtask

    task automatic t_clear();
        chk("R8 not empty before", 32'(fifo_empty), 0);
        ctl_write(1'b1, 1'b1, 1'b1);
        chk("R9 clr bit reads 0", 32'(ctl_rdata[2]), 0);
        chk("R8 req withheld in pulse", 32'(bus_req), 0);
        @(negedge clk);
        #1;
        chk("R8 empty set", 32'(fifo_empty), 1);
        chk("R8 full clear", 32'(fifo_full), 0);
        chk("R8 four_plus set", 32'(fifo_four_plus), 1);
        chk("R9 en/thr read back", 32'(ctl_rdata), 32'b011);
        chk("R8 req back after pulse", 32'(bus_req), 1);
        chk("R8 count kept", 32'(xfer_count), 6);
        ctl_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_done();
        flush();
        load_cnt(16'd3);
        ctl_write(1'b1, 1'b0, 1'b0);
        grant_cycles(5, 32'h0000_3000);
        chk("R7 count zero", 32'(xfer_count), 0);
        chk("R7 done set", 32'(xfer_done), 1);
        chk("R7 req dropped", 32'(bus_req), 0);
        pop_one(); pop_one(); pop_one();
        chk("R7 exactly 3 words", 32'(fifo_empty), 1);
        load_cnt(16'd2);
        chk("R7 load clears done", 32'(xfer_done), 0);
        ctl_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_resume();
        flush();
        load_cnt(16'd5);
        ctl_write(1'b1, 1'b0, 1'b0);
        grant_cycles(2, 32'hBEEF_0000);
        ctl_write(1'b0, 1'b0, 1'b0);
        bus_gnt = 1'b1;
        bus_data = 32'hDEAD_0000;
        #1;
        chk("R1 suspended no req", 32'(bus_req), 0);
        @(negedge clk); @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk("R1 suspended count held", 32'(xfer_count), 3);
        ctl_write(1'b1, 1'b0, 1'b0);
        chk("R11 resume req", 32'(bus_req), 1);
        grant_cycles(3, 32'hBEEF_0002);
        chk("R11 count done", 32'(xfer_count), 0);
        chk("R11 done", 32'(xfer_done), 1);
        for (int i = 0; i < 5; i++) begin
            chk("R11 words in order", pop_data, 32'hBEEF_0000 + 32'(i));
            pop_one();
        end
        chk("R11 no extra word", 32'(fifo_empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_gate();
        t_fill_order();
        t_threshold();
        t_clear();
        t_done();
        t_resume();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule